// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between the peripheral request lines of a chip and its DMA channels. Each of 75 request inputs owns an 8-bit map register. The register holds a channel number and a valid bit. A request line whose register is valid drives the selected channel. A request line whose register is not valid has no effect. Several lines may share one channel: the channel then sees the OR of them.

For each channel the block keeps a registered request level. It also produces two one-cycle events that a channel status block consumes:
- a request-after-service event when the channel level goes from low to high;
- an end-of-receive event when the channel level goes from high to low.

Software reaches the map registers through a simple write/read port. Registers 0 to 63 sit in a first window and registers 64 to 74 sit in a second, separate window. A valid mapping that names a channel beyond the configured channel count sets a sticky error output. The written value is still stored.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every map register reads 0x00, and all channel levels, request-after-service events, end-of-receive events and the error output are 0.
- R2: A word-aligned write at byte offset 0x100 + 4*i (i = 0..63) stores the 8-bit value in map register i, and a read at that offset returns it.
- R3: Map register i for i = 64..74 is written and read at byte offset 0x1100 + 4*(i-64).
- R4: A write to an offset outside both windows, or with address bits 1:0 not zero, changes no map register, and a read there returns 0x00.
- R5: A request line whose map register has bit 7 = 0 (not valid) does not affect any channel level or event.
- R6: The level of channel c on `chan_lvl_o[c]` equals, one clock after the inputs, the OR of all request lines whose map register is valid with bits 4:0 equal to c.
- R7: `ras_o[c]` is 1 for exactly the one cycle in which `chan_lvl_o[c]` goes from 0 to 1, and is 0 in every other cycle.
- R8: `eor_o[c]` is 1 for exactly the one cycle in which `chan_lvl_o[c]` goes from 1 to 0, and is 0 in every other cycle.
- R9: When two request lines map to one channel, a second line rising while the first is high raises no event, and the end-of-receive event appears only when both lines are low.
- R10: Writing a value with bit 7 = 1 and bits 4:0 >= NUM_CH sets `map_err_o`. It stays set until reset, and the value is still stored and read back. A request on such a mapping drives no channel. A value with bit 7 = 0 never sets the error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Byte offset for register access |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| dreq_i | input | NUM_REQ (75) | Peripheral request lines |
| chan_lvl_o | output | NUM_CH (16) | Registered request level per channel |
| ras_o | output | NUM_CH (16) | Request-after-service event per channel |
| eor_o | output | NUM_CH (16) | End-of-receive event per channel |
| map_err_o | output | 1 | Sticky out-of-range mapping error |

## Verification
A map write is stored at the clock edge where `reg_we` is sampled. The read port is combinational, so the new value can be read as soon as that edge has passed. The error flag updates at that same edge.

Channel levels and both events are registered once. They reflect the request inputs present before an edge just after that edge. Each event lasts exactly one cycle.

The bench changes inputs on the falling edge and samples 1 ns after the following rising edge. Each check therefore looks at the first cycle in which a result is due, and no later.

// File: rtl/dmamap_pkg.sv
package dmamap_pkg;
    localparam int ADDR_W      = 16;
    localparam int MAP_W       = 8;
    localparam int SEL_W       = 5;
    localparam int VLD_BIT     = 7;
    localparam int WIN_A_COUNT = 64;
    localparam logic [ADDR_W-1:0] WIN_A_BASE = 16'h0100;
    localparam logic [ADDR_W-1:0] WIN_B_BASE = 16'h1100;
endpackage

// File: rtl/dmamap_regs.sv
module dmamap_regs
    import dmamap_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     we,
    input  logic [MAP_W-1:0]         wdata,
    output logic [MAP_W-1:0]         rdata,
    output logic [NUM_REQ-1:0]       valid_o,
    output logic [NUM_REQ*SEL_W-1:0] sel_o,
    output logic                     err_o
);
    localparam int IDX_W   = $clog2(NUM_REQ);
    localparam int B_COUNT = NUM_REQ - WIN_A_COUNT;
    localparam logic [ADDR_W-1:0] A_LAST = WIN_A_BASE + ADDR_W'(4 * (WIN_A_COUNT - 1));
    localparam logic [ADDR_W-1:0] B_LAST = WIN_B_BASE + ADDR_W'(4 * (B_COUNT - 1));

    typedef struct {
        logic [MAP_W-1:0] map [NUM_REQ];
        logic             err;
    } regs_t;

    regs_t st_d, st_q;

    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] off_a, off_b;

    // Address decode over the two windows
    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        off_a = (addr - WIN_A_BASE) >> 2;
        off_b = (addr - WIN_B_BASE) >> 2;
        if (addr[1:0] == 2'b00) begin
            if (addr >= WIN_A_BASE && addr <= A_LAST) begin
                hit = 1'b1;
                idx = IDX_W'(off_a);
            end else if (addr >= WIN_B_BASE && addr <= B_LAST) begin
                hit = 1'b1;
                idx = IDX_W'(WIN_A_COUNT) + IDX_W'(off_b);
            end
        end
    end

    always_comb begin
        rdata = hit ? st_q.map[idx] : '0;
    end

    // Next-state
    always_comb begin
        st_d = st_q;
        if (we && hit) begin
            st_d.map[idx] = wdata;
            if (wdata[VLD_BIT] && (int'(wdata[SEL_W-1:0]) >= NUM_CH)) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                st_q.map[r] <= '0;
            end
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_out
        assign valid_o[r]                 = st_q.map[r][VLD_BIT];
        assign sel_o[r*SEL_W +: SEL_W]    = st_q.map[r][SEL_W-1:0];
    end

    assign err_o = st_q.err;
endmodule

// File: rtl/dmamap_router.sv
module dmamap_router
    import dmamap_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic [NUM_REQ-1:0]       req_i,
    input  logic [NUM_REQ-1:0]       valid_i,
    input  logic [NUM_REQ*SEL_W-1:0] sel_i,
    output logic [NUM_CH-1:0]        lvl_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic any_d;
        always_comb begin
            any_d = 1'b0;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (valid_i[r] && req_i[r] &&
                    (sel_i[r*SEL_W +: SEL_W] == SEL_W'(c))) begin
                    any_d = 1'b1;
                end
            end
        end
        assign lvl_o[c] = any_d;
    end
endmodule

// File: rtl/dmamap_edge.sv
module dmamap_edge #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] lvl_i,
    output logic [NUM_CH-1:0] lvl_o,
    output logic [NUM_CH-1:0] rise_o,
    output logic [NUM_CH-1:0] fall_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] lvl;
        logic [NUM_CH-1:0] rise;
        logic [NUM_CH-1:0] fall;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d.lvl  = lvl_i;
        st_d.rise = lvl_i & ~st_q.lvl;
        st_d.fall = ~lvl_i & st_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o  = st_q.lvl;
    assign rise_o = st_q.rise;
    assign fall_o = st_q.fall;
endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
    import dmamap_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        reg_addr,
    input  logic               reg_we,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic [NUM_REQ-1:0] dreq_i,
    output logic [NUM_CH-1:0]  chan_lvl_o,
    output logic [NUM_CH-1:0]  ras_o,
    output logic [NUM_CH-1:0]  eor_o,
    output logic               map_err_o
);
    logic [NUM_REQ-1:0]       map_valid;
    logic [NUM_REQ*SEL_W-1:0] map_sel;
    logic [NUM_CH-1:0]        lvl_comb;

    dmamap_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .valid_o (map_valid),
        .sel_o   (map_sel),
        .err_o   (map_err_o)
    );

    dmamap_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_route (
        .req_i   (dreq_i),
        .valid_i (map_valid),
        .sel_i   (map_sel),
        .lvl_o   (lvl_comb)
    );

    dmamap_edge #(.NUM_CH(NUM_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_comb),
        .lvl_o  (chan_lvl_o),
        .rise_o (ras_o),
        .fall_o (eor_o)
    );
endmodule

// File: rtl/dmamap_chk.sv
module dmamap_chk #(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] dreq_i,
    input logic [NUM_CH-1:0]  chan_lvl_o,
    input logic [NUM_CH-1:0]  ras_o,
    input logic [NUM_CH-1:0]  eor_o,
    input logic               map_err_o
);
    assert_ras_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o & ($past(chan_lvl_o) | ~chan_lvl_o)) == '0);

    assert_eor_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eor_o & (~$past(chan_lvl_o) | chan_lvl_o)) == '0);

    assert_no_dual_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_o & eor_o) == '0);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        map_err_o |=> map_err_o);

    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_i == '0) |=> (chan_lvl_o == '0));
endmodule

bind dma_req_mapper dmamap_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq_i     (dreq_i),
    .chan_lvl_o (chan_lvl_o),
    .ras_o      (ras_o),
    .eor_o      (eor_o),
    .map_err_o  (map_err_o)
);

// File: tb/tb_dma_req_mapper.sv
`timescale 1ns/1ps
module tb_dma_req_mapper;
    localparam int NUM_REQ = 75;
    localparam int NUM_CH  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [15:0]        reg_addr = '0;
    logic               reg_we = 1'b0;
    logic [7:0]         reg_wdata = '0;
    logic [7:0]         reg_rdata;
    logic [NUM_REQ-1:0] dreq_i = '0;
    logic [NUM_CH-1:0]  chan_lvl_o, ras_o, eor_o;
    logic               map_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dma_req_mapper #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq_i(dreq_i),
        .chan_lvl_o(chan_lvl_o), .ras_o(ras_o), .eor_o(eor_o), .map_err_o(map_err_o)
    );

    // Two lines (5 in window A, 70 in window B) both mapped to channel 3.
    // Fields: {req5, req70, exp_lvl, exp_ras, exp_eor}
    localparam logic [4:0] VEC [10] = '{
        5'b00_000, 5'b10_110, 5'b11_100, 5'b01_100, 5'b00_001,
        5'b01_110, 5'b01_100, 5'b11_100, 5'b10_100, 5'b00_001
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(string req, logic [15:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, 32'(reg_rdata), 32'(exp));
    endtask

    task automatic drive_req(logic [NUM_REQ-1:0] v);
        @(negedge clk);
        dreq_i = v;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check("R1 map0", 16'h0100, 8'h00);
        rd_check("R1 map74", 16'h1128, 8'h00);
        check("R1 lvl", 32'(chan_lvl_o), 32'h0);
        check("R1 ras", 32'(ras_o), 32'h0);
        check("R1 eor", 32'(eor_o), 32'h0);
        check("R1 err", 32'(map_err_o), 32'h0);

        // R2 / R3: both windows, ends of each
        wr(16'h0100, 8'h81); rd_check("R2 reg0", 16'h0100, 8'h81);
        wr(16'h01FC, 8'h8F); rd_check("R2 reg63", 16'h01FC, 8'h8F);
        wr(16'h1100, 8'h62); rd_check("R3 reg64", 16'h1100, 8'h62);
        wr(16'h1128, 8'h0C); rd_check("R3 reg74", 16'h1128, 8'h0C);

        // R4: misaligned and out-of-window accesses
        wr(16'h01FE, 8'hAA); rd_check("R4 misaligned", 16'h01FC, 8'h8F);
        rd_check("R4 misaligned read", 16'h01FE, 8'h00);
        wr(16'h112C, 8'h55); rd_check("R4 past winB", 16'h112C, 8'h00);
        rd_check("R4 winB last kept", 16'h1128, 8'h0C);
        rd_check("R4 gap read", 16'h0200, 8'h00);
        check("R4 err untouched", 32'(map_err_o), 32'h0);

        // Clear earlier maps so they route nothing
        wr(16'h0100, 8'h00); wr(16'h01FC, 8'h00);

        // R6/R7/R8/R9: table walk, req5 at 0x114 and req70 at 0x1118 -> ch 3
        wr(16'h0114, 8'h83);
        wr(16'h1118, 8'h83);
        rd_check("R3 reg70", 16'h1118, 8'h83);
        for (int i = 0; i < 10; i++) begin
            logic [NUM_REQ-1:0] v;
            v = '0;
            v[5]  = VEC[i][4];
            v[70] = VEC[i][3];
            drive_req(v);
            check($sformatf("R6 lvl step%0d", i), 32'(chan_lvl_o), 32'(VEC[i][2]) << 3);
            check($sformatf("R7 ras step%0d", i), 32'(ras_o), 32'(VEC[i][1]) << 3);
            check($sformatf("R8 eor step%0d R9", i), 32'(eor_o), 32'(VEC[i][0]) << 3);
        end

        // R7: event is a single cycle while level stays high
        drive_req({{(NUM_REQ-6){1'b0}}, 1'b1, 5'b0});
        check("R7 ras rise", 32'(ras_o), 32'h8);
        drive_req({{(NUM_REQ-6){1'b0}}, 1'b1, 5'b0});
        check("R7 ras one cycle", 32'(ras_o), 32'h0);
        drive_req('0);
        check("R8 eor fall", 32'(eor_o), 32'h8);

        // R5: invalid mapping (reg10 at 0x128 = ch2, valid clear)
        wr(16'h0128, 8'h02);
        begin
            logic [NUM_REQ-1:0] v;
            v = '0; v[10] = 1'b1;
            drive_req(v);
        end
        check("R5 lvl", 32'(chan_lvl_o), 32'h0);
        check("R5 ras", 32'(ras_o), 32'h0);
        drive_req('0);
        check("R5 eor", 32'(eor_o), 32'h0);

        // R10: out-of-range channel (reg20 at 0x150)
        wr(16'h0150, 8'h14);
        check("R10 no err when invalid", 32'(map_err_o), 32'h0);
        wr(16'h0150, 8'h94);
        check("R10 err set", 32'(map_err_o), 32'h1);
        rd_check("R10 stored", 16'h0150, 8'h94);
        begin
            logic [NUM_REQ-1:0] v;
            v = '0; v[20] = 1'b1;
            drive_req(v);
        end
        check("R10 no channel", 32'(chan_lvl_o), 32'h0);
        drive_req('0);
        wr(16'h0150, 8'h00);
        check("R10 sticky", 32'(map_err_o), 32'h1);

        done = 1'b1;
        finish_run();
    end
endmodule